// File: doc/BRIEF.md
# Character-Cell CRT Timing Generator

This block produces the raster timing for a text-mode display built from fixed-size character cells. It advances once per character time, on a clock enable, and keeps three positions: the character time inside a scan line, the scan line inside a character row, and the scan line inside the frame. From these it drives horizontal sync, vertical sync, vertical blank, a display enable and the 4-bit scan-line index within the current row, which a character generator outside the block uses to pick the cell's pixel line.

A field-rate input chooses one of two vertical profiles, 60 Hz or 50 Hz. The profiles differ in blanking length and in where vertical sync falls. A change on this input is taken only at a frame boundary. A small load port writes a 12-bit value into one of three address registers: the first address of the page, a row-start override, and the cursor position. The block keeps a running character address for memory fetch, and it raises a cursor flag wherever that address matches the cursor register inside the visible area. All geometry is fixed by parameters. The defaults give a 7x10 dot cell, 80 of 100 character times visible, and 24 visible rows.

Top module: `crt_timing_gen`

## Requirements
- R1: A scan line lasts 100 enabled character times. Display enable is high during the first 80 of them, and only on the 240 visible scan lines of a frame.
- R2: Horizontal sync is active high for exactly 4 character times. It starts on the first blanked character time (position 80) with no delay.
- R3: The row line index `line_o` counts 0 to 9 once per scan line over 24 rows, giving 240 visible lines. It is 0 throughout vertical blanking.
- R4: In 60 Hz mode (`field_50_i` = 0) vertical blank is high for 20 lines (a 260-line frame). Vertical sync is active low on frame lines 244 to 253.
- R5: In 50 Hz mode (`field_50_i` = 1) vertical blank is high for 72 lines (a 312-line frame). Vertical sync is active low on frame lines 270 to 279.
- R6: `field_50_i` is sampled only on the last character time of a frame, so the frame under way always completes with its own profile. After reset the 60 Hz profile is in force.
- R7: While `char_en_i` is low, no timing position advances and no timing output changes.
- R8: On any clock, `ld_sel_i` = 1 loads the page register, 2 loads the row-start register and 3 loads the cursor register from `ld_addr_i`. A value of 0 changes no register.
- R9: `addr_o` is the current row base plus the character position. The row base is taken from the page register at each frame start and grows by 80 at each row end. The exception is a row end that follows a row-start load: that row end uses the row-start register instead, once. Addresses wrap modulo 4096.
- R10: `cursor_o` is high exactly when display enable is high and `addr_o` equals the cursor register. This holds on every scan line of the matching row.
- R11: While `rst_ni` is low, all positions return to the first visible character of the first visible line and all three registers clear to zero. The outputs are then hsync 0, vsync 1, vblank 0, line 0, display enable 1, address 0 and cursor 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_en_i | input | 1 | Character-time enable |
| field_50_i | input | 1 | Field-rate select: 0 = 60 Hz, 1 = 50 Hz |
| ld_sel_i | input | 2 | Register select: 0 none, 1 page, 2 row start, 3 cursor |
| ld_addr_i | input | 12 | Value to load |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_no | output | 1 | Vertical sync, active low |
| vblank_o | output | 1 | Vertical blank, active high |
| line_o | output | 4 | Scan line within the character row |
| disp_en_o | output | 1 | Visible area |
| addr_o | output | 12 | Running character address |
| cursor_o | output | 1 | Cursor match in the visible area |

## Verification
The bench changes the field rate in the middle of a frame. A design that switched at once would cut that frame's blanking short or stretch it, and move the sync window; this shows up as a vertical-blank or vertical-sync mismatch many lines before the frame ends. A page value loaded during blanking must not reach the address until the next frame. A row-start load must redirect exactly one row and then give way to the +80 step again; a design that keeps the override would repeat rows, and one that ignores it would miss the cursor hit placed in the redirected region. A stretch with the enable low checks that no position moves, and a select-0 write with a stray value checks that the cursor target is left alone.

// File: rtl/crt_timing_pkg.sv
package crt_timing_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned LINE_W = 4;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PAGE = 2'd1,
    SEL_ROW  = 2'd2,
    SEL_CUR  = 2'd3
  } ld_sel_e;
endpackage

// File: rtl/crt_htiming.sv
module crt_htiming #(
  parameter int unsigned H_VIS  = 80,
  parameter int unsigned H_TOT  = 100,
  parameter int unsigned HS_DLY = 0,
  parameter int unsigned HS_W   = 4,
  parameter int unsigned COL_W  = $clog2(H_TOT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             char_en_i,
  output logic [COL_W-1:0] col_o,
  output logic             hblank_o,
  output logic             hsync_o,
  output logic             line_end_o
);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(H_TOT - 1);
  localparam logic [COL_W-1:0] COL_VIS  = COL_W'(H_VIS);
  localparam logic [COL_W-1:0] HS_ON    = COL_W'(H_VIS + HS_DLY);
  localparam logic [COL_W-1:0] HS_OFF   = COL_W'(H_VIS + HS_DLY + HS_W);

  logic [COL_W-1:0] col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        col_q <= '0;
    else if (char_en_i) col_q <= (col_q == COL_LAST) ? '0 : col_q + 1'b1;
  end

  assign col_o      = col_q;
  assign hblank_o   = col_q >= COL_VIS;
  assign hsync_o    = (col_q >= HS_ON) && (col_q < HS_OFF);
  assign line_end_o = char_en_i && (col_q == COL_LAST);
endmodule

// File: rtl/crt_vtiming.sv
module crt_vtiming #(
  parameter int unsigned ROW_LINES = 10,
  parameter int unsigned V_ROWS    = 24,
  parameter int unsigned VB_60     = 20,
  parameter int unsigned VB_50     = 72,
  parameter int unsigned VS_DLY_60 = 4,
  parameter int unsigned VS_DLY_50 = 30,
  parameter int unsigned VS_W      = 10,
  parameter int unsigned VL_W      = 9
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                line_adv_i,
  input  logic                                field_50_i,
  output logic [crt_timing_pkg::LINE_W-1:0]   line_o,
  output logic                                vblank_o,
  output logic                                vsync_no,
  output logic                                row_end_o,
  output logic                                frame_end_o,
  output logic                                mode_50_o
);
  import crt_timing_pkg::*;

  localparam int unsigned V_VIS = ROW_LINES * V_ROWS;
  localparam logic [VL_W-1:0]   VIS_END  = VL_W'(V_VIS);
  localparam logic [VL_W-1:0]   LAST_60  = VL_W'(V_VIS + VB_60 - 1);
  localparam logic [VL_W-1:0]   LAST_50  = VL_W'(V_VIS + VB_50 - 1);
  localparam logic [VL_W-1:0]   VSON_60  = VL_W'(V_VIS + VS_DLY_60);
  localparam logic [VL_W-1:0]   VSON_50  = VL_W'(V_VIS + VS_DLY_50);
  localparam logic [VL_W-1:0]   VS_LEN   = VL_W'(VS_W);
  localparam logic [LINE_W-1:0] LIR_LAST = LINE_W'(ROW_LINES - 1);

  logic [VL_W-1:0]   vline_q;
  logic [LINE_W-1:0] lir_q;
  logic              mode_q;
  logic [VL_W-1:0]   v_last, vs_on;
  logic              at_last, in_vis;

  assign v_last  = mode_q ? LAST_50 : LAST_60;
  assign vs_on   = mode_q ? VSON_50 : VSON_60;
  assign at_last = vline_q == v_last;
  assign in_vis  = vline_q < VIS_END;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vline_q <= '0;
      lir_q   <= '0;
      mode_q  <= 1'b0;
    end else if (line_adv_i) begin
      if (at_last) begin
        vline_q <= '0;
        lir_q   <= '0;
        mode_q  <= field_50_i;
      end else begin
        vline_q <= vline_q + 1'b1;
        if (in_vis) lir_q <= (lir_q == LIR_LAST) ? '0 : lir_q + 1'b1;
      end
    end
  end

  assign line_o      = lir_q;
  assign vblank_o    = !in_vis;
  assign vsync_no    = !((vline_q >= vs_on) && (vline_q < vs_on + VS_LEN));
  assign row_end_o   = line_adv_i && in_vis && (lir_q == LIR_LAST);
  assign frame_end_o = line_adv_i && at_last;
  assign mode_50_o   = mode_q;
endmodule

// File: rtl/crt_addr_unit.sv
module crt_addr_unit #(
  parameter int unsigned H_VIS = 80,
  parameter int unsigned COL_W = 7
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [COL_W-1:0]                  col_i,
  input  logic                              visible_i,
  input  logic                              row_end_i,
  input  logic                              frame_end_i,
  input  logic [1:0]                        ld_sel_i,
  input  logic [crt_timing_pkg::ADDR_W-1:0] ld_addr_i,
  output logic [crt_timing_pkg::ADDR_W-1:0] addr_o,
  output logic                              cursor_o
);
  import crt_timing_pkg::*;

  localparam logic [ADDR_W-1:0] ROW_STEP = ADDR_W'(H_VIS);

  ld_sel_e           sel;
  logic [ADDR_W-1:0] page_q, rs_q, cur_q, base_q;
  logic              pend_q;

  assign sel = ld_sel_e'(ld_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      rs_q   <= '0;
      cur_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      case (sel)
        SEL_PAGE: page_q <= ld_addr_i;
        SEL_ROW:  rs_q   <= ld_addr_i;
        SEL_CUR:  cur_q  <= ld_addr_i;
        default:  ;
      endcase
      // a load in the same cycle as a row end arms the following row
      if (sel == SEL_ROW) pend_q <= 1'b1;
      else if (row_end_i) pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          base_q <= '0;
    else if (frame_end_i) base_q <= page_q;
    else if (row_end_i)   base_q <= pend_q ? rs_q : base_q + ROW_STEP;
  end

  assign addr_o   = base_q + {{(ADDR_W-COL_W){1'b0}}, col_i};
  assign cursor_o = visible_i && (addr_o == cur_q);
endmodule

// File: rtl/crt_timing_gen.sv
module crt_timing_gen #(
  parameter int unsigned H_VIS     = 80,
  parameter int unsigned H_TOT     = 100,
  parameter int unsigned HS_DLY    = 0,
  parameter int unsigned HS_W      = 4,
  parameter int unsigned ROW_LINES = 10,
  parameter int unsigned V_ROWS    = 24,
  parameter int unsigned VB_60     = 20,
  parameter int unsigned VB_50     = 72,
  parameter int unsigned VS_DLY_60 = 4,
  parameter int unsigned VS_DLY_50 = 30,
  parameter int unsigned VS_W      = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        char_en_i,
  input  logic        field_50_i,
  input  logic [1:0]  ld_sel_i,
  input  logic [11:0] ld_addr_i,
  output logic        hsync_o,
  output logic        vsync_no,
  output logic        vblank_o,
  output logic [3:0]  line_o,
  output logic        disp_en_o,
  output logic [11:0] addr_o,
  output logic        cursor_o
);
  localparam int unsigned COL_W = $clog2(H_TOT);
  localparam int unsigned V_MAX = ROW_LINES * V_ROWS + ((VB_50 > VB_60) ? VB_50 : VB_60);
  localparam int unsigned VL_W  = $clog2(V_MAX);

  logic [COL_W-1:0] col;
  logic             hblank, line_end, row_end, frame_end, mode_50, vblank;

  crt_htiming #(
    .H_VIS(H_VIS), .H_TOT(H_TOT), .HS_DLY(HS_DLY), .HS_W(HS_W), .COL_W(COL_W)
  ) u_h (
    .clk_i(clk_i), .rst_ni(rst_ni), .char_en_i(char_en_i),
    .col_o(col), .hblank_o(hblank), .hsync_o(hsync_o), .line_end_o(line_end)
  );

  crt_vtiming #(
    .ROW_LINES(ROW_LINES), .V_ROWS(V_ROWS), .VB_60(VB_60), .VB_50(VB_50),
    .VS_DLY_60(VS_DLY_60), .VS_DLY_50(VS_DLY_50), .VS_W(VS_W), .VL_W(VL_W)
  ) u_v (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_adv_i(line_end), .field_50_i(field_50_i),
    .line_o(line_o), .vblank_o(vblank), .vsync_no(vsync_no),
    .row_end_o(row_end), .frame_end_o(frame_end), .mode_50_o(mode_50)
  );

  assign vblank_o  = vblank;
  assign disp_en_o = !hblank && !vblank;

  crt_addr_unit #(.H_VIS(H_VIS), .COL_W(COL_W)) u_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .col_i(col), .visible_i(disp_en_o),
    .row_end_i(row_end), .frame_end_i(frame_end),
    .ld_sel_i(ld_sel_i), .ld_addr_i(ld_addr_i),
    .addr_o(addr_o), .cursor_o(cursor_o)
  );
endmodule

// File: rtl/crt_timing_chk.sv
module crt_timing_chk #(
  parameter int unsigned H_VIS     = 80,
  parameter int unsigned ROW_LINES = 10,
  parameter int unsigned COL_W     = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             char_en_i,
  input logic [COL_W-1:0] col_i,
  input logic             frame_end_i,
  input logic             mode_50_i,
  input logic             hsync_o,
  input logic             vsync_no,
  input logic             vblank_o,
  input logic [3:0]       line_o,
  input logic             disp_en_o,
  input logic             cursor_o
);
  assert_hsync_in_hblank_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_o |-> (col_i >= COL_W'(H_VIS)));

  assert_vsync_in_vblank_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_no |-> vblank_o);

  assert_line_zero_blank_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_o |-> (line_o == 4'd0));

  assert_line_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o < 4'(ROW_LINES));

  assert_mode_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> $stable(mode_50_i));

  assert_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !char_en_i |=> $stable(col_i));

  assert_cursor_visible_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cursor_o |-> disp_en_o);
endmodule

bind crt_timing_gen crt_timing_chk #(
  .H_VIS(H_VIS), .ROW_LINES(ROW_LINES), .COL_W(COL_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .char_en_i(char_en_i), .col_i(col),
  .frame_end_i(frame_end), .mode_50_i(mode_50),
  .hsync_o(hsync_o), .vsync_no(vsync_no), .vblank_o(vblank_o),
  .line_o(line_o), .disp_en_o(disp_en_o), .cursor_o(cursor_o)
);

// File: tb/tb_crt_timing_gen.sv
`timescale 1ns/1ps
module tb_crt_timing_gen;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        char_en = 1'b0;
  logic        field_50 = 1'b0;
  logic [1:0]  ld_sel = 2'd0;
  logic [11:0] ld_addr = '0;
  logic        hsync, vsync_n, vblank, disp_en, cursor;
  logic [3:0]  line;
  logic [11:0] addr;

  always #2 clk = ~clk;

  crt_timing_gen dut (
    .clk_i(clk), .rst_ni(rst_ni), .char_en_i(char_en), .field_50_i(field_50),
    .ld_sel_i(ld_sel), .ld_addr_i(ld_addr),
    .hsync_o(hsync), .vsync_no(vsync_n), .vblank_o(vblank), .line_o(line),
    .disp_en_o(disp_en), .addr_o(addr), .cursor_o(cursor)
  );

  typedef struct {
    bit hs, vs, vb, de, cur, m50;
    logic [3:0]  line;
    logic [11:0] addr;
    string tag;
  } exp_t;

  exp_t q[$];
  int errors = 0, checks = 0;
  bit done = 1'b0;
  string tag = "";

  // reference state, built from the requirements
  int m_h = 0, m_v = 0, m_lir = 0;
  bit m_mode = 0, m_pend = 0;
  logic [11:0] m_top = '0, m_rs = '0, m_cur = '0, m_base = '0;

  task automatic chk(int act, int exp, string req, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(bit ce, bit f50, logic [1:0] sel, logic [11:0] a);
    exp_t e;
    bit row_end = 0;
    int vd;
    char_en = ce; field_50 = f50; ld_sel = sel; ld_addr = a;
    if (ce) begin
      if (m_h == 99) begin
        m_h = 0;
        if (m_v == (m_mode ? 312 : 260) - 1) begin
          m_v = 0; m_lir = 0; m_mode = f50; m_base = m_top;
        end else begin
          if (m_v < 240) begin
            if (m_lir == 9) begin
              row_end = 1; m_lir = 0;
              m_base = m_pend ? m_rs : m_base + 12'd80;
            end else m_lir++;
          end
          m_v++;
        end
      end else m_h++;
    end
    if (row_end) m_pend = 0;
    case (sel)
      2'd1: m_top = a;
      2'd2: begin m_rs = a; m_pend = 1; end
      2'd3: m_cur = a;
      default: ;
    endcase
    vd = m_mode ? 30 : 4;
    e.de = (m_h < 80) && (m_v < 240);
    e.hs = (m_h >= 80) && (m_h < 84);
    e.vb = m_v >= 240;
    e.vs = !((m_v >= 240 + vd) && (m_v < 250 + vd));
    e.line = 4'(m_lir);
    e.addr = m_base + 12'(m_h);
    e.cur = e.de && (e.addr == m_cur);
    e.m50 = m_mode;
    e.tag = ce ? tag : "R7";
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic run(int n, bit ce = 1);
    for (int i = 0; i < n; i++) step(ce, field_50, 2'd0, 12'h000);
  endtask

  task automatic load(logic [1:0] sel, logic [11:0] a);
    step(1'b1, field_50, sel, a);
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        string vr;
        e = q.pop_front();
        vr = e.m50 ? "R5" : "R4";
        chk(int'(disp_en), int'(e.de),  {"R1", e.tag}, "disp_en");
        chk(int'(hsync),   int'(e.hs),  {"R2", e.tag}, "hsync");
        chk(int'(line),    int'(e.line), {"R3", e.tag}, "line");
        chk(int'(vblank),  int'(e.vb),  {vr, e.tag}, "vblank");
        chk(int'(vsync_n), int'(e.vs),  {vr, e.tag}, "vsync_n");
        chk(int'(addr),    int'(e.addr), {"R9", e.tag}, "addr");
        chk(int'(cursor),  int'(e.cur), {"R10", e.tag}, "cursor");
      end
    end
  end

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(int'(hsync), 0, "R11", "hsync");
    chk(int'(vsync_n), 1, "R11", "vsync_n");
    chk(int'(vblank), 0, "R11", "vblank");
    chk(int'(line), 0, "R11", "line");
    chk(int'(disp_en), 1, "R11", "disp_en");
    chk(int'(addr), 0, "R11", "addr");
    chk(int'(cursor), 1, "R11", "cursor");
    rst_ni = 1'b1;
    // R8: cursor at row 2 column 7, then a select-0 write that must not land
    load(2'd3, 12'd167);
    tag = "_R8";
    load(2'd0, 12'h555);
    run(3000);
    // R7: enable held low
    tag = "";
    run(40, 1'b0);
    run(7000);
    // R6: 50 Hz requested mid-frame, takes effect next frame
    field_50 = 1'b1;
    tag = "_R6";
    run(15000);
    // page and cursor loaded during blanking, effective next frame (R9, R10)
    load(2'd1, 12'h100);
    load(2'd3, 12'h1F3);
    run(6000);
    // row-start override at row 5 of frame 2, cursor in redirected region
    load(2'd2, 12'h800);
    load(2'd3, 12'h8A2);
    field_50 = 1'b0;
    run(53000);
    @(posedge clk);
    #2;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule